// File: doc/BRIEF.md
# Locked index/data configuration port

This block is the configuration front end of a peripheral-rich I/O chip. Software reaches it through a two-byte window. The byte at offset 0 is the index port and the byte at offset 1 is the data port. A read strobe and a write strobe qualify each access. After reset the port is closed. It opens only when a fixed four-byte key has been written to the index port. Once open, an index write picks a configuration register and a data access reads or writes that register.

The register space has two parts. The low part holds chip-wide entries: a logical-device selector, a 16-bit chip identifier and a revision nibble. Indices 0x30 and above are banked by the logical-device selector. Each downstream device owns an enable register and a 16-bit base-address register. These are exported on flat output vectors so that the bus decoder and the devices can use them. Writing the exit pair closes the port again, and the register contents are kept.

Top module: `sio_cfg_port`

## Requirements
- R1: `portSel` = 0 addresses the index port and `portSel` = 1 addresses the data port. While open, reading the index port returns the current index value, which is 0x00 after reset.
- R2: The port opens after 0x87, 0x01, 0x55, 0x55 have been written in that order to the index port. Data-port accesses between key bytes neither advance nor break the sequence.
- R3: An index-port byte that does not match the expected key byte restarts detection. If that byte equals 0x87 it counts as the first key byte.
- R4: While closed, data-port writes change no register and no output. Reads of either port return 0xFF.
- R5: While open, writing 0x02 to the index port and then 0x02 to the data port closes the port and clears the index to 0x00. A data value other than 0x02 at index 0x02 has no effect. The selector, enables and bases are kept across the close.
- R6: Index 0x07 is a read/write logical-device selector. It chooses which device bank indices 0x30 and up refer to.
- R7: Index 0x20 reads the chip identifier's high byte and index 0x21 reads its low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 at zero. These three are read-only. Any other unused index reads 0x00.
- R8: Index 0x30 is the selected device's enable. Bit 0 is stored and read back as {7'b0, bit0}, and it drives `devActive[ldn]`.
- R9: Index 0x60 is the high byte and index 0x61 is the low byte of the selected device's base address. Together they drive `devBase[16*ldn +: 16]`.
- R10: When the selector is NUM_DEV or larger, banked indices read 0xFF and banked writes are dropped.
- R11: Reset closes the port and zeroes the selector, the index, every enable and every base. `rdData` resets to 0xFF.
- R12: `rdData` loads on the clock edge that samples `rdEn` and holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one access per cycle |
| rdEn | input | 1 | Read strobe |
| portSel | input | 1 | 0 = index port, 1 = data port |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| devActive | output | NUM_DEV | Enable bit per logical device |
| devBase | output | 16*NUM_DEV | Base address per logical device, device d at bits 16*d+15:16*d |

## Verification
All state changes take effect on the edge that samples a write strobe. An enable or base output therefore shows a data write one cycle later. The open/closed state changes on the edge of the last key byte or of the exit write.

`rdData` is due one cycle after the read strobe. The bench drives every access on a falling edge and holds it for one cycle. It samples results on the next falling edge, which comes half a period after the edge that loaded them. The hold check samples `rdData` again after several idle cycles.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int KEY_LEN = 4;
  localparam int KEY_W   = $clog2(KEY_LEN);
  localparam logic [7:0] UNLOCK_KEY [KEY_LEN] = '{8'h87, 8'h01, 8'h55, 8'h55};

  localparam logic       PORT_INDEX = 1'b0;
  localparam logic       PORT_DATA  = 1'b1;

  localparam logic [7:0] IDX_EXIT   = 8'h02;
  localparam logic [7:0] VAL_EXIT   = 8'h02;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_ID_HI  = 8'h20;
  localparam logic [7:0] IDX_ID_LO  = 8'h21;
  localparam logic [7:0] IDX_REV    = 8'h22;
  localparam logic [7:0] IDX_BANK   = 8'h30;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_BASE_H = 8'h60;
  localparam logic [7:0] IDX_BASE_L = 8'h61;

  typedef struct packed {
    logic ldnWr;
    logic actWr;
    logic baseHiWr;
    logic baseLoWr;
    logic rdIdx;
    logic rdReg;
    logic rdLock;
  } cfgStrobe_t;

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       portSel,
  input  logic [7:0] wrData,
  output logic       cfgOpen,
  output logic [7:0] idxReg,
  output cfgStrobe_t strb
);

  localparam logic [KEY_W-1:0] KEY_LAST = KEY_W'(KEY_LEN - 1);

  logic [KEY_W-1:0] keyPos;
  logic idxWr;
  logic dataWr;
  logic exitHit;

  assign idxWr   = wrEn && (portSel == PORT_INDEX);
  assign dataWr  = cfgOpen && wrEn && (portSel == PORT_DATA);
  assign exitHit = dataWr && (idxReg == IDX_EXIT) && (wrData == VAL_EXIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgOpen <= 1'b0;
      keyPos  <= '0;
      idxReg  <= 8'h00;
    end else if (!cfgOpen) begin
      if (idxWr) begin
        if (wrData == UNLOCK_KEY[keyPos]) begin
          if (keyPos == KEY_LAST) begin
            cfgOpen <= 1'b1;
            keyPos  <= '0;
          end else begin
            keyPos <= keyPos + 1'b1;
          end
        end else if (wrData == UNLOCK_KEY[0]) begin
          keyPos <= KEY_W'(1);
        end else begin
          keyPos <= '0;
        end
      end
    end else begin
      if (idxWr) begin
        idxReg <= wrData;
      end else if (exitHit) begin
        cfgOpen <= 1'b0;
        idxReg  <= 8'h00;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.ldnWr    = dataWr && (idxReg == IDX_LDN);
    strb.actWr    = dataWr && (idxReg == IDX_ACT);
    strb.baseHiWr = dataWr && (idxReg == IDX_BASE_H);
    strb.baseLoWr = dataWr && (idxReg == IDX_BASE_L);
    strb.rdIdx    = rdEn && cfgOpen && (portSel == PORT_INDEX);
    strb.rdReg    = rdEn && cfgOpen && (portSel == PORT_DATA);
    strb.rdLock   = rdEn && !cfgOpen;
  end

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_DEV  = 4,
  parameter logic [15:0] CHIP_ID  = 16'h5A31,
  parameter logic [3:0]  CHIP_REV = 4'h3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strb,
  input  logic [7:0]           idxReg,
  input  logic [7:0]           wrData,
  output logic [7:0]           rdData,
  output logic [NUM_DEV-1:0]   devActive,
  output logic [16*NUM_DEV-1:0] devBase
);

  localparam int         LDN_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [7:0] DEV_LIMIT = 8'(NUM_DEV);

  logic [7:0]       ldnReg;
  logic [LDN_W-1:0] ldnSel;
  logic             bankOk;
  logic [15:0]      selBase;
  logic [7:0]       regVal;

  assign ldnSel = ldnReg[LDN_W-1:0];
  assign bankOk = ldnReg < DEV_LIMIT;

  always_ff @(posedge clk) begin
    if (!rstN) ldnReg <= 8'h00;
    else if (strb.ldnWr) ldnReg <= wrData;
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic        hit;
    logic        actQ;
    logic [15:0] baseQ;

    assign hit = bankOk && (ldnSel == LDN_W'(d));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actQ  <= 1'b0;
        baseQ <= 16'h0000;
      end else if (hit) begin
        if (strb.actWr)    actQ         <= wrData[0];
        if (strb.baseHiWr) baseQ[15:8]  <= wrData;
        if (strb.baseLoWr) baseQ[7:0]   <= wrData;
      end
    end

    assign devActive[d]        = actQ;
    assign devBase[16*d +: 16] = baseQ;
  end

  assign selBase = devBase[{ldnSel, 4'b0000} +: 16];

  always_comb begin
    regVal = 8'h00;
    if (idxReg >= IDX_BANK) begin
      if (!bankOk) regVal = 8'hFF;
      else begin
        case (idxReg)
          IDX_ACT:    regVal = {7'b0, devActive[ldnSel]};
          IDX_BASE_H: regVal = selBase[15:8];
          IDX_BASE_L: regVal = selBase[7:0];
          default:    regVal = 8'h00;
        endcase
      end
    end else begin
      case (idxReg)
        IDX_LDN:   regVal = ldnReg;
        IDX_ID_HI: regVal = CHIP_ID[15:8];
        IDX_ID_LO: regVal = CHIP_ID[7:0];
        IDX_REV:   regVal = {4'h0, CHIP_REV};
        default:   regVal = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= 8'hFF;
    else if (strb.rdLock) rdData <= 8'hFF;
    else if (strb.rdIdx) rdData <= idxReg;
    else if (strb.rdReg) rdData <= regVal;
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_DEV  = 4,
  parameter logic [15:0] CHIP_ID  = 16'h5A31,
  parameter logic [3:0]  CHIP_REV = 4'h3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic                  portSel,
  input  logic [7:0]            wrData,
  output logic [7:0]            rdData,
  output logic [NUM_DEV-1:0]    devActive,
  output logic [16*NUM_DEV-1:0] devBase
);

  logic       cfgOpen;
  logic [7:0] idxReg;
  cfgStrobe_t strb;

  sio_cfg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .portSel (portSel),
    .wrData  (wrData),
    .cfgOpen (cfgOpen),
    .idxReg  (idxReg),
    .strb    (strb)
  );

  sio_cfg_regs #(
    .NUM_DEV  (NUM_DEV),
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .idxReg    (idxReg),
    .wrData    (wrData),
    .rdData    (rdData),
    .devActive (devActive),
    .devBase   (devBase)
  );

endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk #(
  parameter int NUM_DEV = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic                  portSel,
  input logic [7:0]            wrData,
  input logic [7:0]            rdData,
  input logic [NUM_DEV-1:0]    devActive,
  input logic [16*NUM_DEV-1:0] devBase,
  input logic                  cfgOpen,
  input logic [7:0]            idxReg
);

  p_locked_read_ff_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !cfgOpen) |=> (rdData == 8'hFF));

  p_locked_no_effect_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOpen |=> ($stable(devActive) && $stable(devBase)));

  p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgOpen) |-> $past(wrEn && !portSel && (wrData == 8'h55)));

  p_exit_closes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOpen && wrEn && portSel && (idxReg == 8'h02) && (wrData == 8'h02))
      |=> (!cfgOpen && (idxReg == 8'h00)));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind sio_cfg_port sio_cfg_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .portSel   (portSel),
  .wrData    (wrData),
  .rdData    (rdData),
  .devActive (devActive),
  .devBase   (devBase),
  .cfgOpen   (cfgOpen),
  .idxReg    (idxReg)
);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/1ps
module sim_sio_cfg_port;

  localparam int NUM_DEV = 4;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  wrEn = 1'b0;
  logic                  rdEn = 1'b0;
  logic                  portSel = 1'b0;
  logic [7:0]            wrData = 8'h00;
  logic [7:0]            rdData;
  logic [NUM_DEV-1:0]    devActive;
  logic [16*NUM_DEV-1:0] devBase;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sio_cfg_port #(.NUM_DEV(NUM_DEV), .CHIP_ID(16'h5A31), .CHIP_REV(4'h3)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .portSel(portSel),
    .wrData(wrData), .rdData(rdData), .devActive(devActive), .devBase(devBase)
  );

  // Vector layout: {req[3:0], op[1:0], port, data[7:0], expect[7:0]}
  localparam logic [1:0] OW = 2'd0;
  localparam logic [1:0] OR = 2'd1;
  localparam logic PI = 1'b0;
  localparam logic PD = 1'b1;
  localparam int NV = 74;
  localparam logic [22:0] VEC [NV] = '{
    {4'd4, OR, PI, 8'h00, 8'hFF},   // R4 closed read
    {4'd2, OW, PI, 8'h87, 8'h00},
    {4'd2, OW, PI, 8'h01, 8'h00},
    {4'd2, OW, PI, 8'h55, 8'h00},
    {4'd2, OW, PI, 8'h55, 8'h00},
    {4'd1, OR, PI, 8'h00, 8'h00},   // R1 index reads 0
    {4'd7, OW, PI, 8'h20, 8'h00},
    {4'd7, OR, PD, 8'h00, 8'h5A},   // R7 id high
    {4'd7, OW, PI, 8'h21, 8'h00},
    {4'd7, OR, PD, 8'h00, 8'h31},   // R7 id low
    {4'd7, OW, PI, 8'h22, 8'h00},
    {4'd7, OR, PD, 8'h00, 8'h03},   // R7 revision
    {4'd6, OW, PI, 8'h07, 8'h00},
    {4'd6, OW, PD, 8'h02, 8'h00},
    {4'd6, OR, PD, 8'h00, 8'h02},   // R6 selector readback
    {4'd8, OW, PI, 8'h30, 8'h00},
    {4'd8, OW, PD, 8'hFF, 8'h00},
    {4'd8, OR, PD, 8'h00, 8'h01},   // R8 only bit 0 kept
    {4'd9, OW, PI, 8'h60, 8'h00},
    {4'd9, OW, PD, 8'h12, 8'h00},
    {4'd9, OW, PI, 8'h61, 8'h00},
    {4'd9, OW, PD, 8'h34, 8'h00},
    {4'd9, OR, PD, 8'h00, 8'h34},   // R9 base low
    {4'd9, OW, PI, 8'h60, 8'h00},
    {4'd9, OR, PD, 8'h00, 8'h12},   // R9 base high
    {4'd6, OW, PI, 8'h07, 8'h00},
    {4'd6, OW, PD, 8'h01, 8'h00},
    {4'd6, OW, PI, 8'h30, 8'h00},
    {4'd6, OR, PD, 8'h00, 8'h00},   // R6 other bank idle
    {4'd10, OW, PI, 8'h07, 8'h00},
    {4'd10, OW, PD, 8'h07, 8'h00},
    {4'd10, OW, PI, 8'h30, 8'h00},
    {4'd10, OW, PD, 8'h01, 8'h00},
    {4'd10, OR, PD, 8'h00, 8'hFF},  // R10 bank out of range
    {4'd10, OW, PI, 8'h60, 8'h00},
    {4'd10, OR, PD, 8'h00, 8'hFF},  // R10
    {4'd6, OW, PI, 8'h07, 8'h00},
    {4'd6, OW, PD, 8'h02, 8'h00},
    {4'd6, OW, PI, 8'h30, 8'h00},
    {4'd6, OR, PD, 8'h00, 8'h01},   // R6 bank 2 intact
    {4'd7, OW, PI, 8'h25, 8'h00},
    {4'd7, OR, PD, 8'h00, 8'h00},   // R7 unused index
    {4'd5, OW, PI, 8'h02, 8'h00},
    {4'd5, OW, PD, 8'h03, 8'h00},
    {4'd5, OR, PI, 8'h00, 8'h02},   // R5 wrong exit value, still open
    {4'd5, OW, PD, 8'h02, 8'h00},
    {4'd5, OR, PI, 8'h00, 8'hFF},   // R5 closed
    {4'd4, OR, PD, 8'h00, 8'hFF},   // R4 closed data read
    {4'd4, OW, PD, 8'h00, 8'h00},
    {4'd3, OW, PI, 8'h87, 8'h00},
    {4'd3, OW, PI, 8'h01, 8'h00},
    {4'd3, OW, PI, 8'h87, 8'h00},
    {4'd3, OW, PI, 8'h01, 8'h00},
    {4'd3, OW, PI, 8'h55, 8'h00},
    {4'd3, OW, PI, 8'h55, 8'h00},
    {4'd3, OR, PI, 8'h00, 8'h00},   // R3 reopened, R5 index cleared
    {4'd5, OW, PI, 8'h07, 8'h00},
    {4'd5, OR, PD, 8'h00, 8'h02},   // R5 selector kept
    {4'd4, OW, PI, 8'h30, 8'h00},
    {4'd4, OR, PD, 8'h00, 8'h01},   // R4 closed write did nothing
    {4'd5, OW, PI, 8'h02, 8'h00},
    {4'd5, OW, PD, 8'h02, 8'h00},
    {4'd3, OW, PI, 8'h87, 8'h00},
    {4'd3, OW, PI, 8'h01, 8'h00},
    {4'd3, OW, PI, 8'h55, 8'h00},
    {4'd3, OW, PI, 8'h00, 8'h00},
    {4'd3, OW, PI, 8'h55, 8'h00},
    {4'd3, OR, PI, 8'h00, 8'hFF},   // R3 broken key stays closed
    {4'd2, OW, PI, 8'h87, 8'h00},
    {4'd2, OW, PI, 8'h01, 8'h00},
    {4'd2, OW, PI, 8'h55, 8'h00},
    {4'd2, OW, PD, 8'h12, 8'h00},
    {4'd2, OW, PI, 8'h55, 8'h00},
    {4'd2, OR, PI, 8'h00, 8'h00}    // R2 data access does not break key
  };

  task automatic access(input logic w, input logic r, input logic p, input logic [7:0] d);
    @(negedge clk);
    wrEn = w; rdEn = r; portSel = p; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic unlock();
    access(1'b1, 1'b0, PI, 8'h87);
    access(1'b1, 1'b0, PI, 8'h01);
    access(1'b1, 1'b0, PI, 8'h55);
    access(1'b1, 1'b0, PI, 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 enables at reset", 64'(devActive), 64'h0);
    check("R11 bases at reset", 64'(devBase), 64'h0);
    check("R11 rdData at reset", 64'(rdData), 64'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      if (v[18:17] == OW) access(1'b1, 1'b0, v[16], v[15:8]);
      else begin
        access(1'b0, 1'b1, v[16], 8'h00);
        check($sformatf("R%0d vector %0d", v[22:19], i), 64'(rdData), 64'(v[7:0]));
      end
    end

    check("R8 devActive port", 64'(devActive), 64'h4);
    check("R9 devBase port", 64'(devBase), {16'h0, 16'h1234, 16'h0, 16'h0});

    access(1'b1, 1'b0, PI, 8'h07);
    access(1'b0, 1'b1, PD, 8'h00);
    check("R12 read after one cycle", 64'(rdData), 64'h02);
    repeat (3) @(negedge clk);
    check("R12 read data held", 64'(rdData), 64'h02);
    access(1'b1, 1'b0, PD, 8'h03);
    check("R12 held across write", 64'(rdData), 64'h02);

    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R11 enables after reset", 64'(devActive), 64'h0);
    check("R11 bases after reset", 64'(devBase), 64'h0);
    check("R11 rdData after reset", 64'(rdData), 64'hFF);
    access(1'b0, 1'b1, PI, 8'h00);
    check("R11 closed after reset", 64'(rdData), 64'hFF);
    unlock();
    access(1'b1, 1'b0, PI, 8'h07);
    access(1'b0, 1'b1, PD, 8'h00);
    check("R11 selector cleared", 64'(rdData), 64'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule